// File: doc/BRIEF.md
# Two-Sample-Per-Cycle 5/3 Wavelet Analysis Filter

This block performs a single-level, one-dimensional forward wavelet split of an image line with the 5/3 filter pair. Each clock cycle it can accept two neighbouring samples: the even-indexed one and the odd-indexed one that follows it. It returns one low-band coefficient and one high-band coefficient per accepted pair. The low band and the high band each have their own shift-and-add datapath, and both work from the same short window of stored samples. The block therefore keeps up with a two-samples-per-cycle stream and does not alternate between the two outputs.

At both ends of a line the samples are mirrored about the end sample, so no coefficient uses data from outside the current line. The incoming stream frames each line with a start marker on its first pair and an end marker on its last pair. A small controller with four states handles the line ends. IDLE waits for a start marker. PRIME holds the first pair of a line. STREAM emits one coefficient pair for every new pair. DRAIN emits the last coefficient pair, which uses the right-hand mirror. The transitions are: IDLE→PRIME on a start pair, IDLE→DRAIN on a start pair that also carries the end marker, PRIME→STREAM and STREAM→STREAM on a plain pair, PRIME→DRAIN and STREAM→DRAIN on the end pair, DRAIN→PRIME (or DRAIN→DRAIN) when the next line's start pair arrives in the drain cycle, and DRAIN→IDLE otherwise.

Top module: `dual_rate_wavelet53`

## Requirements
- R1: A pair is accepted when `in_valid` is high. `in_even` carries line sample 2p and `in_odd` carries sample 2p+1. A line is LINE_LEN/2 accepted pairs: `in_sol` is set on the first pair and `in_eol` on the last.
- R2: `out_low` is floor((6·x[2n] + 2·(x[2n-1]+x[2n+1]) − x[2n-2] − x[2n+2] + 4) / 8), in two's complement DW+2 bits.
- R3: `out_high` is floor((2·x[2n+1] − x[2n] − x[2n+2] + 1) / 2), in two's complement DW+2 bits, and it is exact over the full signed input range.
- R4: At the start of a line the samples are mirrored: x[-1] = x[1] and x[-2] = x[2].
- R5: At the end of a line of length N the sample beyond the end is mirrored: x[N] = x[N-2].
- R6: Coefficient pair n is registered, with `out_valid` high, on the clock edge that accepts pair n+1. The edge that accepts pair 0 produces no output. The last coefficient pair appears on the edge after the end pair. A line sent without gaps therefore yields one coefficient pair per cycle.
- R7: A new line's start pair may arrive in the cycle in which the previous line drains. Both are honoured, and the next line's results are unaffected.
- R8: A valid pair without `in_sol` that arrives while no line is open (in IDLE or DRAIN) is ignored and produces no output.
- R9: While reset is held and after it is released, `out_valid` is low and the block waits for a start pair.
- R10: Cycles with `in_valid` low in the middle of a line produce no output and do not change any coefficient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair present |
| in_sol | input | 1 | Pair is the first of a line |
| in_eol | input | 1 | Pair is the last of a line |
| in_even | input | DW | Even-indexed sample, signed |
| in_odd | input | DW | Odd-indexed sample, signed |
| out_valid | output | 1 | Coefficient pair present |
| out_low | output | DW+2 | Low-band coefficient, signed |
| out_high | output | DW+2 | High-band coefficient, signed |

## Verification
The risky overlap is the DRAIN cycle. In that cycle the block emits the mirrored last coefficient of one line and, if the start pair of the next line arrives, also loads that pair. The bench sends two lines back to back so that the next start pair lands exactly in the drain cycle. The scoreboard then checks the last coefficients of the first line and every coefficient of the second line, including the cycle in which each one appears. A second case puts a pair without a start marker into the drain cycle and checks that the drain output is still correct and that no further output follows.

// File: rtl/wav53_pkg.sv
package wav53_pkg;

    // Line-framing controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // no line open
        ST_PRIME  = 2'd1,   // first pair of a line held
        ST_STREAM = 2'd2,   // mid-line, one output per accepted pair
        ST_DRAIN  = 2'd3    // last output pending, right mirror applied
    } wav_state_e;

endpackage

// File: rtl/wav53_lo_path.sv
module wav53_lo_path #(
    parameter int DW = 16,
    parameter int OW = DW + 2
) (
    input  logic signed [DW-1:0] m2,
    input  logic signed [DW-1:0] m1,
    input  logic signed [DW-1:0] c0,
    input  logic signed [DW-1:0] p1,
    input  logic signed [DW-1:0] p2,
    output logic signed [OW-1:0] low
);
    // Four guard bits carry the full tap gain of 12 in eighths
    localparam int AW = DW + 4;

    logic signed [AW-1:0] w_m2, w_m1, w_c0, w_p1, w_p2;
    logic signed [AW-1:0] acc, biased;

    always_comb begin
        w_m2   = AW'(m2);
        w_m1   = AW'(m1);
        w_c0   = AW'(c0);
        w_p1   = AW'(p1);
        w_p2   = AW'(p2);
        // 6*c + 2*(left+right) - outer pair, all in eighths
        acc    = (w_c0 <<< 2) + (w_c0 <<< 1) + ((w_m1 + w_p1) <<< 1) - w_m2 - w_p2;
        biased = acc + $signed({{(AW-3){1'b0}}, 3'b100});
        low    = OW'(biased >>> 3);
    end

endmodule

// File: rtl/wav53_hi_path.sv
module wav53_hi_path #(
    parameter int DW = 16,
    parameter int OW = DW + 2
) (
    input  logic signed [DW-1:0] left,
    input  logic signed [DW-1:0] mid,
    input  logic signed [DW-1:0] right,
    output logic signed [OW-1:0] high
);
    localparam int AW = DW + 3;

    logic signed [AW-1:0] acc, biased;

    always_comb begin
        // 2*odd - both even neighbours, in halves
        acc    = (AW'(mid) <<< 1) - AW'(left) - AW'(right);
        biased = acc + $signed({{(AW-1){1'b0}}, 1'b1});
        high   = OW'(biased >>> 1);
    end

endmodule

// File: rtl/dual_rate_wavelet53.sv
module dual_rate_wavelet53
    import wav53_pkg::*;
#(
    parameter int DW       = 16,
    parameter int LINE_LEN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sol,
    input  logic                  in_eol,
    input  logic signed [DW-1:0]  in_even,
    input  logic signed [DW-1:0]  in_odd,
    output logic                  out_valid,
    output logic signed [DW+1:0]  out_low,
    output logic signed [DW+1:0]  out_high
);
    localparam int OW    = DW + 2;
    localparam int PAIRS = LINE_LEN / 2;
    localparam int CW    = $clog2(PAIRS) + 1;

    wav_state_e state, nxt_state;

    // Sample window: previous pair (prv_*) and pending pair (cur_*)
    logic signed [DW-1:0] prv_e, prv_o, cur_e, cur_o;
    logic                 head;       // pending pair is the first of its line
    logic [CW-1:0]        pair_cnt;   // pairs taken in the open line

    logic start_line, advance, emit, draining;
    logic signed [DW-1:0] nxt_e, tap_m2, tap_m1;
    logic signed [OW-1:0] lo_res, hi_res;

    always_comb begin
        draining   = (state == ST_DRAIN);
        start_line = in_valid && in_sol && (state == ST_IDLE || draining);
        advance    = in_valid && (state == ST_PRIME || state == ST_STREAM);
        emit       = advance || draining;
        // Right edge: the sample past the end mirrors onto x[N-2]
        nxt_e      = draining ? cur_e : in_even;
        // Left edge: x[-2] mirrors onto x[2], x[-1] onto x[1]
        tap_m2     = head ? nxt_e : prv_e;
        tap_m1     = head ? cur_o : prv_o;
    end

    wav53_lo_path #(.DW(DW), .OW(OW)) u_lo (
        .m2 (tap_m2),
        .m1 (tap_m1),
        .c0 (cur_e),
        .p1 (cur_o),
        .p2 (nxt_e),
        .low(lo_res)
    );

    wav53_hi_path #(.DW(DW), .OW(OW)) u_hi (
        .left (cur_e),
        .mid  (cur_o),
        .right(nxt_e),
        .high (hi_res)
    );

    // Next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (in_valid && in_sol)
                    nxt_state = in_eol ? ST_DRAIN : ST_PRIME;
            end
            ST_PRIME, ST_STREAM: begin
                if (in_valid)
                    nxt_state = in_eol ? ST_DRAIN : ST_STREAM;
            end
            ST_DRAIN: begin
                if (in_valid && in_sol)
                    nxt_state = in_eol ? ST_DRAIN : ST_PRIME;
                else
                    nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt_state;
    end

    // Window and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_e     <= '0;
            prv_o     <= '0;
            cur_e     <= '0;
            cur_o     <= '0;
            head      <= 1'b0;
            pair_cnt  <= '0;
            out_valid <= 1'b0;
            out_low   <= '0;
            out_high  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_low  <= lo_res;
                out_high <= hi_res;
            end
            if (start_line) begin
                cur_e    <= in_even;
                cur_o    <= in_odd;
                head     <= 1'b1;
                pair_cnt <= CW'(1);
            end else if (advance) begin
                prv_e    <= cur_e;
                prv_o    <= cur_o;
                cur_e    <= in_even;
                cur_o    <= in_odd;
                head     <= 1'b0;
                pair_cnt <= pair_cnt + CW'(1);
            end
        end
    end

    // Assertions
    AST_EOL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (in_eol == (pair_cnt == CW'(PAIRS - 1)))); // R1

    AST_FIRST_PAIR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_valid && in_sol && !in_eol) |=> !out_valid); // R6

    AST_STREAM_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> out_valid); // R6

    AST_DRAIN_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> out_valid); // R5

    AST_RESTART_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && in_valid && in_sol) |=> (out_valid && state != ST_IDLE)); // R7

    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(in_valid && in_sol)) |=> (!out_valid && state == ST_IDLE)); // R8

    AST_GAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !in_valid) |=> (!out_valid && $stable(out_low) && $stable(out_high))); // R10

endmodule

// File: tb/dual_rate_wavelet53_bench.sv
module dual_rate_wavelet53_bench;
    localparam int DW  = 16;
    localparam int LEN = 8;
    localparam int M   = LEN / 2;
    localparam int OW  = DW + 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, in_valid, in_sol, in_eol;
    logic signed [DW-1:0] in_even, in_odd;
    logic out_valid;
    logic signed [OW-1:0] out_low, out_high;

    dual_rate_wavelet53 #(.DW(DW), .LINE_LEN(LEN)) u_dual_rate_wavelet53 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_eol(in_eol), .in_even(in_even), .in_odd(in_odd),
        .out_valid(out_valid), .out_low(out_low), .out_high(out_high)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int lo; int hi; int at; string tag; } exp_t;
    typedef int line_t [LEN];

    exp_t sb[$];
    exp_t cur;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    function automatic int xm(line_t xs, int i);
        if (i < 0) i = -i;                  // R4
        if (i >= LEN) i = 2 * (LEN - 1) - i; // R5
        return xs[i];
    endfunction

    function automatic int ref_lo(line_t xs, int k);
        int s;
        s = 6 * xm(xs, 2*k) + 2 * (xm(xs, 2*k-1) + xm(xs, 2*k+1))
            - xm(xs, 2*k-2) - xm(xs, 2*k+2);
        return (s + 4) >>> 3;
    endfunction

    function automatic int ref_hi(line_t xs, int k);
        int s;
        s = 2 * xm(xs, 2*k+1) - xm(xs, 2*k) - xm(xs, 2*k+2);
        return (s + 1) >>> 1;
    endfunction

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sol   = 1'b0;
        in_eol   = 1'b0;
    endtask

    task automatic drive_pair(input int e, input int o, input bit s, input bit l, output int at);
        @(negedge clk);
        in_valid = 1'b1;
        in_even  = e[DW-1:0];
        in_odd   = o[DW-1:0];
        in_sol   = s;
        in_eol   = l;
        at       = cyc;
    endtask

    task automatic push_item(line_t xs, int k, int at, string tag);
        exp_t it;
        it.lo  = ref_lo(xs, k);
        it.hi  = ref_hi(xs, k);
        it.at  = at;
        it.tag = (k == 0) ? {tag, " R4"} : ((k == M - 1) ? {tag, " R5"} : tag);
        sb.push_back(it);
    endtask

    // Sends one line; a gap of gap_len idle cycles precedes pair gap_at.
    task automatic run_line(line_t xs, int gap_at, int gap_len, bit hold, string tag);
        int at;
        for (int k = 0; k < M; k++) begin
            if (k == gap_at) repeat (gap_len) idle_cycle();
            drive_pair(xs[2*k], xs[2*k+1], k == 0, k == M - 1, at);
            if (k > 0) push_item(xs, k - 1, at + 1, tag); // R6 timing
        end
        push_item(xs, M - 1, at + 2, tag);
        if (!hold) idle_cycle();
    endtask

    task automatic expect_quiet(string req);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: out_valid=%0b expected 0", req, out_valid);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R6/R8: unexpected output lo=%0d hi=%0d at cycle %0d, expected none",
                         out_low, out_high, cyc);
            end else begin
                cur = sb.pop_front();
                if (int'(out_low) != cur.lo || int'(out_high) != cur.hi || cyc != cur.at) begin
                    n_bad++;
                    $display("FAIL %s R6: lo=%0d hi=%0d cyc=%0d expected lo=%0d hi=%0d cyc=%0d",
                             cur.tag, out_low, out_high, cyc, cur.lo, cur.hi, cur.at);
                end
            end
        end
    end

    line_t ramp, mixed, ext_a, ext_b, lin_c, lin_d, lin_e;

    initial begin
        int at;
        for (int i = 0; i < LEN; i++) begin
            ramp[i]  = 3 * i - 5;
            mixed[i] = ((i * 37 + 11) % 201) - 100;
            ext_a[i] = (i % 2 == 0) ? 32767 : -32768;
            ext_b[i] = (i % 2 == 0) ? -32768 : 32767;
            lin_c[i] = (i * i) - 20;
            lin_d[i] = 50 - 7 * i + ((i % 3) * 11);
            lin_e[i] = (i < 4) ? 1000 : -1000;
        end
        rst_n = 1'b0; in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
        in_even = '0; in_odd = '0;
        repeat (3) @(negedge clk);
        expect_quiet("R9 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_quiet("R9 after reset");

        // Stray pairs with no line open
        drive_pair(5, 6, 1'b0, 1'b0, at);
        idle_cycle();
        expect_quiet("R8 stray in idle");

        run_line(ramp,  -1, 0, 1'b0, "R1 R2 R3 ramp");
        run_line(mixed, -1, 0, 1'b0, "R2 R3 mixed");
        run_line(ext_a, -1, 0, 1'b0, "R3 extremes a");
        run_line(ext_b, -1, 0, 1'b0, "R3 extremes b");

        // Next start pair lands in the drain cycle
        run_line(lin_c, -1, 0, 1'b1, "R7 first");
        run_line(lin_d, -1, 0, 1'b0, "R7 second");

        // Pair without a start marker in the drain cycle
        run_line(lin_e, -1, 0, 1'b1, "R2 R3 before stray");
        drive_pair(77, -77, 1'b0, 1'b0, at);
        idle_cycle();
        idle_cycle();
        expect_quiet("R8 stray in drain");

        // Gaps inside a line, in PRIME and in STREAM
        run_line(mixed, 1, 2, 1'b0, "R10 gap after first");
        run_line(lin_c, 2, 3, 1'b0, "R10 gap mid-line");

        repeat (5) idle_cycle();
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R6: %0d outputs missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R6: watchdog expired, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule